// File: doc/BRIEF.md
# Tagged Translation Cache

This block is a small fully associative cache of address translations. Each slot keeps a virtual page number, the physical page number it maps to, a set of attribute bits (memory type, cacheability, access rights), a flag marking the mapping as per-process, a process tag and a machine tag. A lookup is purely combinational. The cache returns hit or miss, the physical address and the attributes for the current virtual address, process tag and machine tag.

Slots are written only through a fill port, which a hardware table walker drives after a miss. There is no other write path. Stale translations are removed through a one-cycle invalidation port with four command kinds: flush everything, flush one machine, flush one process inside one machine, or flush a half-open range of virtual pages. Invalidation wins over a fill in the same cycle. A one-cycle done pulse follows each command.

Top module: `tlb_array`

## Requirements
- R1: After reset every slot is empty, so every lookup misses, and inv_done_o is low.
- R2: A lookup hits only when a valid slot has the looked-up virtual page and a machine tag equal to lk_vmid_i. On a hit, lk_pa_o is the slot's physical page concatenated with the 12-bit page offset of lk_va_i, and lk_attr_o is the slot's attributes, in the same cycle.
- R3: A slot filled with fill_ng_i=0 is global and hits for any lk_asid_i. A slot filled with fill_ng_i=1 hits only when lk_asid_i equals its process tag.
- R4: Process tag 0 is reserved. A fill with fill_ng_i=1 and fill_asid_i=0 is ignored and installs nothing.
- R5: A fill goes to the lowest-numbered empty slot. When no slot is empty, it replaces the slot named by a round-robin pointer. The pointer starts at 0 after reset and advances by one, wrapping, only after such a replacement.
- R6: inv_op_i=2'b00 clears every slot, whatever its tags.
- R7: inv_op_i=2'b01 clears every slot whose machine tag equals inv_vmid_i and leaves slots of other machines alone.
- R8: inv_op_i=2'b10 clears only per-process slots whose process tag equals inv_asid_i and whose machine tag equals inv_vmid_i. Global slots stay.
- R9: inv_op_i=2'b11 clears every slot whose virtual page p satisfies inv_base_i <= p < inv_limit_i, whatever its tags.
- R10: When inv_i and fill_i are high in the same cycle, the fill is dropped. A lookup made in the cycle of an invalidation still sees the slots as they were before it.
- R11: inv_done_o is high for exactly the one cycle that follows each cycle with inv_i high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lk_va_i | input | VA_W | Virtual address to translate |
| lk_asid_i | input | ASID_W | Current process tag |
| lk_vmid_i | input | VMID_W | Current machine tag |
| lk_hit_o | output | 1 | Translation found |
| lk_pa_o | output | PA_W | Translated physical address |
| lk_attr_o | output | ATTR_W | Attributes of the matching slot |
| fill_i | input | 1 | Install a translation |
| fill_vpn_i | input | VA_W-12 | Virtual page to install |
| fill_ppn_i | input | PA_W-12 | Physical page to install |
| fill_attr_i | input | ATTR_W | Attributes to install |
| fill_ng_i | input | 1 | 1 = per-process mapping, 0 = global |
| fill_asid_i | input | ASID_W | Process tag of the new slot |
| fill_vmid_i | input | VMID_W | Machine tag of the new slot |
| inv_i | input | 1 | Invalidation command strobe |
| inv_op_i | input | 2 | Command kind: 00 all, 01 machine, 10 process, 11 range |
| inv_vmid_i | input | VMID_W | Machine tag operand |
| inv_asid_i | input | ASID_W | Process tag operand |
| inv_base_i | input | VA_W-12 | First page of the range, inclusive |
| inv_limit_i | input | VA_W-12 | End page of the range, exclusive |
| inv_done_o | output | 1 | Command completion pulse |

## Verification
A wrong tag comparison or a slot that should have been cleared shows at the ports as soon as a lookup is made: a wrong hit or miss, or a physical page that belongs to another process or machine. The next lookup after the offending fill or invalidation reveals it. A wrong victim choice or pointer update stays hidden until a later lookup of the evicted or surviving page, so the replacement order is traced by probing every affected page right after each fill. Done-pulse timing errors appear one cycle after a command.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [1:0] {
    INV_ALL   = 2'b00,
    INV_VM    = 2'b01,
    INV_AS    = 2'b10,
    INV_RANGE = 2'b11
  } inv_op_e;
endpackage

// File: rtl/tlb_slot_cmp.sv
module tlb_slot_cmp
  import tlb_pkg::*;
#(
  parameter int VPN_W  = 36,
  parameter int ASID_W = 16,
  parameter int VMID_W = 8
) (
  input  logic              valid_i,
  input  logic [VPN_W-1:0]  vpn_i,
  input  logic              ng_i,
  input  logic [ASID_W-1:0] asid_i,
  input  logic [VMID_W-1:0] vmid_i,
  input  logic [VPN_W-1:0]  lk_vpn_i,
  input  logic [ASID_W-1:0] lk_asid_i,
  input  logic [VMID_W-1:0] lk_vmid_i,
  input  inv_op_e           inv_op_i,
  input  logic [VMID_W-1:0] inv_vmid_i,
  input  logic [ASID_W-1:0] inv_asid_i,
  input  logic [VPN_W-1:0]  inv_base_i,
  input  logic [VPN_W-1:0]  inv_limit_i,
  output logic              hit_o,
  output logic              kill_o
);
  logic asid_ok;
  logic sel;

  // global slots skip the process tag
  assign asid_ok = !ng_i || (asid_i == lk_asid_i);
  assign hit_o   = valid_i && (vpn_i == lk_vpn_i) && (vmid_i == lk_vmid_i) && asid_ok;

  always_comb begin
    unique case (inv_op_i)
      INV_ALL:   sel = 1'b1;
      INV_VM:    sel = (vmid_i == inv_vmid_i);
      INV_AS:    sel = ng_i && (asid_i == inv_asid_i) && (vmid_i == inv_vmid_i);
      INV_RANGE: sel = (vpn_i >= inv_base_i) && (vpn_i < inv_limit_i);
      default:   sel = 1'b0;
    endcase
  end

  assign kill_o = valid_i && sel;
endmodule

// File: rtl/tlb_victim_sel.sv
module tlb_victim_sel #(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ENTRIES-1:0] valid_i,
  input  logic               adv_i,
  output logic [IDX_W-1:0]   idx_o
);
  logic [IDX_W-1:0] rr_q;
  logic [IDX_W-1:0] free_idx;
  logic             has_free;

  always_comb begin
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_i[i]) free_idx = IDX_W'(i);
    end
  end

  assign has_free = !(&valid_i);
  assign idx_o    = has_free ? free_idx : rr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rr_q <= '0;
    end else if (adv_i && !has_free) begin
      rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
    end
  end

  p_rr_holds_on_free_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && has_free) |=> $stable(rr_q));
  p_rr_steps_on_full_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !has_free) |=> (rr_q != $past(rr_q)));
endmodule

// File: rtl/tlb_array.sv
module tlb_array
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VA_W    = 48,
  parameter int PA_W    = 40,
  parameter int PAGE_W  = 12,
  parameter int ASID_W  = 16,
  parameter int VMID_W  = 8,
  parameter int ATTR_W  = 8,
  localparam int VPN_W  = VA_W - PAGE_W,
  localparam int PPN_W  = PA_W - PAGE_W,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [VA_W-1:0]   lk_va_i,
  input  logic [ASID_W-1:0] lk_asid_i,
  input  logic [VMID_W-1:0] lk_vmid_i,
  output logic              lk_hit_o,
  output logic [PA_W-1:0]   lk_pa_o,
  output logic [ATTR_W-1:0] lk_attr_o,
  input  logic              fill_i,
  input  logic [VPN_W-1:0]  fill_vpn_i,
  input  logic [PPN_W-1:0]  fill_ppn_i,
  input  logic [ATTR_W-1:0] fill_attr_i,
  input  logic              fill_ng_i,
  input  logic [ASID_W-1:0] fill_asid_i,
  input  logic [VMID_W-1:0] fill_vmid_i,
  input  logic              inv_i,
  input  logic [1:0]        inv_op_i,
  input  logic [VMID_W-1:0] inv_vmid_i,
  input  logic [ASID_W-1:0] inv_asid_i,
  input  logic [VPN_W-1:0]  inv_base_i,
  input  logic [VPN_W-1:0]  inv_limit_i,
  output logic              inv_done_o
);
  logic [ENTRIES-1:0] valid_q;
  logic [ENTRIES-1:0] ng_q;
  logic [VPN_W-1:0]   vpn_q  [ENTRIES];
  logic [PPN_W-1:0]   ppn_q  [ENTRIES];
  logic [ATTR_W-1:0]  attr_q [ENTRIES];
  logic [ASID_W-1:0]  asid_q [ENTRIES];
  logic [VMID_W-1:0]  vmid_q [ENTRIES];

  logic [ENTRIES-1:0] hit_vec;
  logic [ENTRIES-1:0] kill_vec;
  logic [IDX_W-1:0]   vic_idx;
  logic               fill_ok;
  logic               done_q;
  logic [PPN_W-1:0]   ppn_sel;
  logic [ATTR_W-1:0]  attr_sel;
  inv_op_e            op;

  assign op      = inv_op_e'(inv_op_i);
  // reserved process tag never labels a per-process mapping
  assign fill_ok = fill_i && !inv_i && !(fill_ng_i && (fill_asid_i == '0));

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    tlb_slot_cmp #(.VPN_W(VPN_W), .ASID_W(ASID_W), .VMID_W(VMID_W)) u_cmp (
      .valid_i    (valid_q[g]),
      .vpn_i      (vpn_q[g]),
      .ng_i       (ng_q[g]),
      .asid_i     (asid_q[g]),
      .vmid_i     (vmid_q[g]),
      .lk_vpn_i   (lk_va_i[VA_W-1:PAGE_W]),
      .lk_asid_i  (lk_asid_i),
      .lk_vmid_i  (lk_vmid_i),
      .inv_op_i   (op),
      .inv_vmid_i (inv_vmid_i),
      .inv_asid_i (inv_asid_i),
      .inv_base_i (inv_base_i),
      .inv_limit_i(inv_limit_i),
      .hit_o      (hit_vec[g]),
      .kill_o     (kill_vec[g])
    );
  end

  tlb_victim_sel #(.ENTRIES(ENTRIES)) u_victim (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(valid_q),
    .adv_i  (fill_ok),
    .idx_o  (vic_idx)
  );

  // AND-OR read mux
  always_comb begin
    ppn_sel  = '0;
    attr_sel = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      ppn_sel  |= ppn_q[i]  & {PPN_W{hit_vec[i]}};
      attr_sel |= attr_q[i] & {ATTR_W{hit_vec[i]}};
    end
  end

  assign lk_hit_o  = |hit_vec;
  assign lk_pa_o   = {ppn_sel, lk_va_i[PAGE_W-1:0]};
  assign lk_attr_o = attr_sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      ng_q    <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        vpn_q[i]  <= '0;
        ppn_q[i]  <= '0;
        attr_q[i] <= '0;
        asid_q[i] <= '0;
        vmid_q[i] <= '0;
      end
    end else if (inv_i) begin
      valid_q <= valid_q & ~kill_vec;
    end else if (fill_ok) begin
      valid_q[vic_idx] <= 1'b1;
      ng_q[vic_idx]    <= fill_ng_i;
      vpn_q[vic_idx]   <= fill_vpn_i;
      ppn_q[vic_idx]   <= fill_ppn_i;
      attr_q[vic_idx]  <= fill_attr_i;
      asid_q[vic_idx]  <= fill_asid_i;
      vmid_q[vic_idx]  <= fill_vmid_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) done_q <= 1'b0;
    else         done_q <= inv_i;
  end
  assign inv_done_o = done_q;

  p_hit_needs_entry_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_hit_o |-> (|valid_q));
  p_reserved_fill_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_i && !inv_i && fill_ng_i && (fill_asid_i == '0)) |=> $stable(valid_q));
  p_fill_grows_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_ok && !(&valid_q)) |=> ($countones(valid_q) == $past($countones(valid_q)) + 1));
  p_flush_all_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inv_i && (inv_op_i == 2'b00)) |=> (valid_q == '0));
  p_inv_blocks_fill_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_i |=> ($countones(valid_q) <= $past($countones(valid_q))));
  p_done_after_cmd_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_i |=> inv_done_o);
  p_done_single_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inv_i |=> !inv_done_o);
endmodule

// File: tb/tlb_array_tb.sv
module tlb_array_tb;
  localparam int VA_W = 48, PA_W = 40, ASID_W = 16, VMID_W = 8, ATTR_W = 8;
  localparam int VPN_W = 36, PPN_W = 28;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [VA_W-1:0]   lk_va = '0;
  logic [ASID_W-1:0] lk_asid = '0;
  logic [VMID_W-1:0] lk_vmid = '0;
  logic              lk_hit;
  logic [PA_W-1:0]   lk_pa;
  logic [ATTR_W-1:0] lk_attr;
  logic              fill = 1'b0;
  logic [VPN_W-1:0]  f_vpn = '0;
  logic [PPN_W-1:0]  f_ppn = '0;
  logic [ATTR_W-1:0] f_attr = '0;
  logic              f_ng = 1'b0;
  logic [ASID_W-1:0] f_asid = '0;
  logic [VMID_W-1:0] f_vmid = '0;
  logic              inv = 1'b0;
  logic [1:0]        i_op = '0;
  logic [VMID_W-1:0] i_vmid = '0;
  logic [ASID_W-1:0] i_asid = '0;
  logic [VPN_W-1:0]  i_base = '0;
  logic [VPN_W-1:0]  i_limit = '0;
  logic              done;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  tlb_array u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .lk_va_i(lk_va), .lk_asid_i(lk_asid), .lk_vmid_i(lk_vmid),
    .lk_hit_o(lk_hit), .lk_pa_o(lk_pa), .lk_attr_o(lk_attr),
    .fill_i(fill), .fill_vpn_i(f_vpn), .fill_ppn_i(f_ppn), .fill_attr_i(f_attr),
    .fill_ng_i(f_ng), .fill_asid_i(f_asid), .fill_vmid_i(f_vmid),
    .inv_i(inv), .inv_op_i(i_op), .inv_vmid_i(i_vmid), .inv_asid_i(i_asid),
    .inv_base_i(i_base), .inv_limit_i(i_limit), .inv_done_o(done)
  );

  typedef struct packed {
    logic [VPN_W-1:0]  vpn;
    logic [11:0]       off;
    logic [ASID_W-1:0] asid;
    logic [VMID_W-1:0] vmid;
    logic              hit;
    logic [PPN_W-1:0]  ppn;
    logic [ATTR_W-1:0] attr;
  } vec_t;

  localparam vec_t TBL [8] = '{
    '{36'h10, 12'habc, 16'd9, 8'd1, 1'b1, 28'h100, 8'h11}, // R3 global, any process
    '{36'h10, 12'h001, 16'd9, 8'd2, 1'b0, 28'h0,   8'h0},  // R2 machine mismatch
    '{36'h20, 12'h123, 16'd5, 8'd1, 1'b1, 28'h200, 8'h22}, // R2
    '{36'h20, 12'h123, 16'd6, 8'd1, 1'b0, 28'h0,   8'h0},  // R3 process mismatch
    '{36'h20, 12'hfff, 16'd5, 8'd2, 1'b1, 28'h400, 8'h44}, // R2 other machine
    '{36'h30, 12'h000, 16'd6, 8'd1, 1'b1, 28'h300, 8'h33}, // R3
    '{36'h31, 12'h000, 16'd6, 8'd1, 1'b0, 28'h0,   8'h0},  // R2 page mismatch
    '{36'h30, 12'h000, 16'd6, 8'd2, 1'b0, 28'h0,   8'h0}   // R2
  };

  task automatic look(input logic [VPN_W-1:0] vpn, input logic [11:0] off,
                      input logic [ASID_W-1:0] asid, input logic [VMID_W-1:0] vmid,
                      input logic exp_hit, input logic [PPN_W-1:0] exp_ppn,
                      input logic [ATTR_W-1:0] exp_attr, input string req);
    lk_va = {vpn, off}; lk_asid = asid; lk_vmid = vmid;
    #1;
    checks++;
    if (lk_hit !== exp_hit ||
        (exp_hit && (lk_pa !== {exp_ppn, off} || lk_attr !== exp_attr))) begin
      errors++;
      $display("FAIL %s vpn=%h: hit=%b pa=%h attr=%h expected hit=%b pa=%h attr=%h",
               req, vpn, lk_hit, lk_pa, lk_attr, exp_hit, {exp_ppn, off}, exp_attr);
    end
  endtask

  task automatic do_fill(input logic [VPN_W-1:0] vpn, input logic [PPN_W-1:0] ppn,
                         input logic [ATTR_W-1:0] attr, input logic ng,
                         input logic [ASID_W-1:0] asid, input logic [VMID_W-1:0] vmid);
    @(negedge clk);
    fill = 1'b1; f_vpn = vpn; f_ppn = ppn; f_attr = attr; f_ng = ng; f_asid = asid; f_vmid = vmid;
    @(negedge clk);
    fill = 1'b0;
  endtask

  task automatic do_inv(input logic [1:0] op, input logic [VMID_W-1:0] vm,
                        input logic [ASID_W-1:0] as, input logic [VPN_W-1:0] b,
                        input logic [VPN_W-1:0] l);
    @(negedge clk);
    inv = 1'b1; i_op = op; i_vmid = vm; i_asid = as; i_base = b; i_limit = l;
    @(negedge clk);
    inv = 1'b0;
    #1;
    checks++;
    if (done !== 1'b1) begin
      errors++; $display("FAIL R11 done after command: got %b expected 1", done);
    end
    @(negedge clk);
    #1;
    checks++;
    if (done !== 1'b0) begin
      errors++; $display("FAIL R11 done second cycle: got %b expected 0", done);
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    look(36'h0, 12'h0, 16'd0, 8'd0, 1'b0, '0, '0, "R1");
    checks++;
    if (done !== 1'b0) begin
      errors++; $display("FAIL R1 done after reset: got %b expected 0", done);
    end

    do_fill(36'h10, 28'h100, 8'h11, 1'b0, 16'd0, 8'd1);
    do_fill(36'h20, 28'h200, 8'h22, 1'b1, 16'd5, 8'd1);
    do_fill(36'h30, 28'h300, 8'h33, 1'b1, 16'd6, 8'd1);
    do_fill(36'h20, 28'h400, 8'h44, 1'b1, 16'd5, 8'd2);
    for (int k = 0; k < 8; k++)
      look(TBL[k].vpn, TBL[k].off, TBL[k].asid, TBL[k].vmid, TBL[k].hit,
           TBL[k].ppn, TBL[k].attr, "R2/R3 table");

    // R8 by process tag within machine 1
    do_inv(2'b10, 8'd1, 16'd5, '0, '0);
    look(36'h20, 12'h0, 16'd5, 8'd1, 1'b0, '0, '0, "R8 cleared");
    look(36'h20, 12'h0, 16'd5, 8'd2, 1'b1, 28'h400, 8'h44, "R8 other machine kept");
    look(36'h30, 12'h0, 16'd6, 8'd1, 1'b1, 28'h300, 8'h33, "R8 other process kept");
    look(36'h10, 12'h0, 16'd5, 8'd1, 1'b1, 28'h100, 8'h11, "R8 global kept");

    // R7 by machine tag
    do_inv(2'b01, 8'd2, 16'd0, '0, '0);
    look(36'h20, 12'h0, 16'd5, 8'd2, 1'b0, '0, '0, "R7 cleared");
    look(36'h10, 12'h0, 16'd1, 8'd1, 1'b1, 28'h100, 8'h11, "R7 other machine kept");

    // R9 range boundaries
    do_fill(36'h40, 28'h540, 8'h01, 1'b0, 16'd0, 8'd3);
    do_fill(36'h41, 28'h541, 8'h02, 1'b1, 16'd7, 8'd3);
    do_fill(36'h42, 28'h542, 8'h03, 1'b0, 16'd0, 8'd3);
    do_inv(2'b11, 8'd0, 16'd0, 36'h41, 36'h42);
    look(36'h40, 12'h0, 16'd7, 8'd3, 1'b1, 28'h540, 8'h01, "R9 below base kept");
    look(36'h41, 12'h0, 16'd7, 8'd3, 1'b0, '0, '0, "R9 base cleared");
    look(36'h42, 12'h0, 16'd7, 8'd3, 1'b1, 28'h542, 8'h03, "R9 limit kept");

    // R6 flush everything
    do_inv(2'b00, 8'd0, 16'd0, '0, '0);
    look(36'h10, 12'h0, 16'd1, 8'd1, 1'b0, '0, '0, "R6 global gone");
    look(36'h40, 12'h0, 16'd7, 8'd3, 1'b0, '0, '0, "R6 other machine gone");

    // R4 reserved process tag
    do_fill(36'h50, 28'h650, 8'h05, 1'b1, 16'd0, 8'd1);
    look(36'h50, 12'h0, 16'd0, 8'd1, 1'b0, '0, '0, "R4 reserved fill ignored");
    do_fill(36'h51, 28'h651, 8'h06, 1'b0, 16'd0, 8'd1);
    look(36'h51, 12'h0, 16'd3, 8'd1, 1'b1, 28'h651, 8'h06, "R4 global tag 0 accepted");

    // R10 invalidation vs fill and lookup in the same cycle
    @(negedge clk);
    inv = 1'b1; i_op = 2'b00;
    fill = 1'b1; f_vpn = 36'h60; f_ppn = 28'h760; f_attr = 8'h07; f_ng = 1'b0;
    f_asid = '0; f_vmid = 8'd1;
    look(36'h51, 12'h0, 16'd3, 8'd1, 1'b1, 28'h651, 8'h06, "R10 lookup sees old state");
    @(negedge clk);
    inv = 1'b0; fill = 1'b0;
    look(36'h60, 12'h0, 16'd0, 8'd1, 1'b0, '0, '0, "R10 fill dropped");
    look(36'h51, 12'h0, 16'd3, 8'd1, 1'b0, '0, '0, "R10 flush applied");
    checks++;
    if (done !== 1'b1) begin
      errors++; $display("FAIL R11 done after combined cycle: got %b expected 1", done);
    end

    // R5 replacement order
    for (int k = 0; k < 16; k++)
      do_fill(36'h100 + 36'(k), 28'h1000 + 28'(k), 8'(k), 1'b0, 16'd0, 8'd1);
    for (int k = 0; k < 16; k++)
      look(36'h100 + 36'(k), 12'h0, 16'd0, 8'd1, 1'b1, 28'h1000 + 28'(k), 8'(k), "R5 all slots used");
    do_fill(36'h200, 28'h2000, 8'hA0, 1'b0, 16'd0, 8'd1);
    look(36'h100, 12'h0, 16'd0, 8'd1, 1'b0, '0, '0, "R5 pointer slot 0 replaced");
    look(36'h200, 12'h0, 16'd0, 8'd1, 1'b1, 28'h2000, 8'hA0, "R5 new entry");
    look(36'h101, 12'h0, 16'd0, 8'd1, 1'b1, 28'h1001, 8'h01, "R5 slot 1 kept");
    do_fill(36'h201, 28'h2001, 8'hA1, 1'b0, 16'd0, 8'd1);
    look(36'h101, 12'h0, 16'd0, 8'd1, 1'b0, '0, '0, "R5 pointer slot 1 replaced");
    do_inv(2'b11, 8'd0, 16'd0, 36'h105, 36'h106);
    do_fill(36'h202, 28'h2002, 8'hA2, 1'b0, 16'd0, 8'd1);
    look(36'h102, 12'h0, 16'd0, 8'd1, 1'b1, 28'h1002, 8'h02, "R5 free slot preferred");
    look(36'h202, 12'h0, 16'd0, 8'd1, 1'b1, 28'h2002, 8'hA2, "R5 free slot filled");
    do_fill(36'h203, 28'h2003, 8'hA3, 1'b0, 16'd0, 8'd1);
    look(36'h102, 12'h0, 16'd0, 8'd1, 1'b0, '0, '0, "R5 pointer held at slot 2");
    look(36'h103, 12'h0, 16'd0, 8'd1, 1'b1, 28'h1003, 8'h03, "R5 slot 3 kept");

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule